// File: doc/BRIEF.md
# Duplicated-Wire Bus Codec with Invert Coding and Single-Error Correction

This block carries a K-bit word across a long on-chip bus of 2K+3 wires and protects it against three problems at once. Every payload bit is driven on two neighbouring wires, so no three adjacent wires can ever show the slow alternating patterns 010 or 101. Before the word leaves, the encoder counts how many duplicated wires would toggle against the word it sent last. If more than half would toggle, it sends the complement and raises an invert flag. The flag also travels on two duplicated wires. A single parity wire turns the duplicated word into a code with minimum distance three.

The parity is formed from the raw data while the invert decision is still being worked out. It is then patched with the invert flag, using the rule that complementing an odd number of XOR inputs flips the XOR output. At the receiving end, the decoder first corrects errors and only then undoes the inversion. It rebuilds the parity from the first copy of the word and compares it with the received parity wire. On a match it takes that copy. Otherwise it takes the second copy. Both directions register their outputs, so each adds one cycle of latency. In a chip the encoder and decoder halves sit at opposite ends of the wires.

Top module: `dapbi_codec`

## Requirements
- R1: After a synchronous active-low reset, `bus_o`, `bus_vld_o`, `dec_vld_o` and `dec_data_o` are all zero, and the stored previously-sent word is zero.
- R2: Wire layout of `bus_o`: wires 2i and 2i+1 both carry bit i of a (K+1)-bit sent word. Bits 0..K-1 of that word are the (possibly complemented) data. Bit K is the invert flag, with 1 meaning complemented. Wire 2K+2 carries the parity.
- R3: The encoder compares the non-inverted duplicated word (flag 0) with wires 0..2K+1 of the last sent word and counts the toggles. When the count is strictly greater than K+1, it sends the complemented data with the flag set. Otherwise it sends the data unchanged with the flag clear.
- R4: The parity wire equals the XOR of the K+1 bits of one copy of the sent word, meaning the data bits as sent plus the flag.
- R5: No three adjacent wires of a valid `bus_o` word ever form 010 or 101.
- R6: `bus_vld_o` follows `enc_vld_i` one cycle later. `bus_o` holds its value while no input is valid, and the stored previous word changes only on valid inputs.
- R7: With an error-free bus, `dec_data_o` equals the original data one cycle after `bus_vld_i`. `dec_vld_o` follows `bus_vld_i` one cycle later.
- R8: A single flipped wire, on any of the 2K+3 wires, is corrected and the original data is delivered.
- R9: `dec_data_o` holds its value while `bus_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_vld_i | input | 1 | Input word valid |
| enc_data_i | input | K | Word to encode |
| bus_o | output | 2K+3 | Encoded wires driven onto the bus |
| bus_vld_o | output | 1 | Encoded wires valid |
| bus_i | input | 2K+3 | Wires received from the bus |
| bus_vld_i | input | 1 | Received wires valid |
| dec_vld_o | output | 1 | Decoded word valid |
| dec_data_o | output | K | Decoded, corrected word |

## Verification
The bench targets the invert threshold from a zero previous word. Four differing bits (eight toggles) must not invert, and five bits must invert; a design with an off-by-one threshold or a threshold counted on data bits only would send the wrong flag. It flips each wire in turn, including the flag pair and the parity wire. A decoder that undid the inversion before correcting, or that picked the wrong copy on a parity mismatch, would return a complemented or corrupted word. The bench also checks across idle gaps whether the previous-word memory was updated on invalid cycles. If it was, a later invert decision would differ from the bench model.

// File: rtl/dapbi_pkg.sv
// Shared types and helpers for the duplicated-wire invert codec.
// Assumes nothing beyond elaboration-time constant arguments.
package dapbi_pkg;

    // Which received copy the decoder trusts.
    typedef enum logic {
        COPY_EVEN = 1'b0,
        COPY_ODD  = 1'b1
    } dapbi_copy_e;

    // True when complementing n XOR inputs flips the XOR result.
    function automatic logic flips_parity(input int unsigned n);
        return logic'(n % 2);
    endfunction

endpackage

// File: rtl/dapbi_popcount.sv
// Counts the ones in a vector. Purely combinational.
// Assumes CW is wide enough to hold W.
module dapbi_popcount #(
    parameter int W  = 18,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    // Sum every bit of the vector.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/dapbi_spread.sv
// Drives each of N bits onto two neighbouring wires (2i, 2i+1).
// Assumes the consumer expects that interleaved layout.
module dapbi_spread #(
    parameter int N = 9
) (
    input  logic [N-1:0]   bits_i,
    output logic [2*N-1:0] wires_o
);

    for (genvar i = 0; i < N; i++) begin : g_pair
        assign wires_o[2*i]   = bits_i[i];
        assign wires_o[2*i+1] = bits_i[i];
    end

endmodule

// File: rtl/dapbi_enc.sv
// Encoder: duplicates data and flag, decides on inversion against the
// last sent word, patches a parity computed from the raw data, and
// registers the result. Assumes a single clock and synchronous reset.
module dapbi_enc #(
    parameter int K = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  logic [K-1:0]       data_i,
    output logic [2*K+2:0]     bus_o,
    output logic               vld_o
);
    import dapbi_pkg::*;

    localparam int NW = K + 1;
    localparam int DW = 2 * NW;
    localparam int BW = DW + 1;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] HALF  = CW'(NW);
    localparam logic          PATCH = flips_parity(NW);

    logic [NW-1:0] plain_w;
    logic [DW-1:0] cand_w;
    logic [DW-1:0] sent_w;
    logic [CW-1:0] flips_w;
    logic          inv_w;
    logic          raw_par_w;
    logic          par_w;
    logic [BW-1:0] bus_q;
    logic          vld_q;

    assign plain_w = {1'b0, data_i};

    dapbi_spread #(.N(NW)) u_spread (
        .bits_i  (plain_w),
        .wires_o (cand_w)
    );

    dapbi_popcount #(.W(DW), .CW(CW)) u_flips (
        .vec_i (cand_w ^ bus_q[DW-1:0]),
        .cnt_o (flips_w)
    );

    // Inversion decision, raw parity and the patch run side by side.
    always_comb begin
        inv_w     = (flips_w > HALF);
        raw_par_w = ^data_i;
        par_w     = raw_par_w ^ (inv_w & PATCH);
        sent_w    = inv_w ? ~cand_w : cand_w;
    end

    // Register the wire word; the stored word doubles as history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_i;
            if (vld_i) begin
                bus_q <= {par_w, sent_w};
            end
        end
    end

    assign bus_o = bus_q;
    assign vld_o = vld_q;

endmodule

// File: rtl/dapbi_dec.sv
// Decoder: rebuilds parity from the even copy, selects a copy, then
// removes the inversion and registers the word. Assumes at most one
// wire in error per word.
module dapbi_dec #(
    parameter int K = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [2*K+2:0] bus_i,
    output logic           vld_o,
    output logic [K-1:0]   data_o
);
    import dapbi_pkg::*;

    localparam int NW = K + 1;
    localparam int DW = 2 * NW;

    logic [NW-1:0] even_w;
    logic [NW-1:0] odd_w;
    logic [NW-1:0] pick_w;
    logic          regen_w;
    dapbi_copy_e   sel_w;
    logic [K-1:0]  plain_w;
    logic [K-1:0]  data_q;
    logic          vld_q;

    for (genvar i = 0; i < NW; i++) begin : g_split
        assign even_w[i] = bus_i[2*i];
        assign odd_w[i]  = bus_i[2*i+1];
    end

    // Correct first, then undo the inversion with the corrected flag.
    always_comb begin
        regen_w = ^even_w;
        sel_w   = (regen_w == bus_i[DW]) ? COPY_EVEN : COPY_ODD;
        pick_w  = (sel_w == COPY_EVEN) ? even_w : odd_w;
        plain_w = pick_w[K-1:0] ^ {K{pick_w[K]}};
    end

    // Capture the decoded word on valid transfers only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= vld_i;
            if (vld_i) begin
                data_q <= plain_w;
            end
        end
    end

    assign data_o = data_q;
    assign vld_o  = vld_q;

endmodule

// File: rtl/dapbi_codec.sv
// Top: encoder and decoder halves of the duplicated-wire invert codec.
// Assumes bus_i is the far end of the wires driven by bus_o.
module dapbi_codec #(
    parameter int K = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enc_vld_i,
    input  logic [K-1:0]   enc_data_i,
    output logic [2*K+2:0] bus_o,
    output logic           bus_vld_o,
    input  logic [2*K+2:0] bus_i,
    input  logic           bus_vld_i,
    output logic           dec_vld_o,
    output logic [K-1:0]   dec_data_o
);

    dapbi_enc #(.K(K)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (enc_vld_i),
        .data_i (enc_data_i),
        .bus_o  (bus_o),
        .vld_o  (bus_vld_o)
    );

    dapbi_dec #(.K(K)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (bus_vld_i),
        .bus_i  (bus_i),
        .vld_o  (dec_vld_o),
        .data_o (dec_data_o)
    );

endmodule

// File: rtl/dapbi_codec_chk.sv
// Checker for dapbi_codec, attached by bind. Keeps its own copy of the
// last valid wire word to bound toggles.
module dapbi_codec_chk #(
    parameter int K = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_vld_i,
    input logic [2*K+2:0] bus_o,
    input logic           bus_vld_o,
    input logic           bus_vld_i,
    input logic           dec_vld_o,
    input logic [K-1:0]   dec_data_o
);
    localparam int NW = K + 1;
    localparam int DW = 2 * NW;
    localparam int BW = DW + 1;

    logic [DW-1:0] last_q;

    function automatic logic bad_pattern(input logic [BW-1:0] w);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i + 2 < BW; i++) begin
            if (w[i] != w[i+1] && w[i+1] != w[i+2]) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic copy_parity(input logic [BW-1:0] w);
        logic p;
        p = 1'b0;
        for (int i = 0; i < NW; i++) p = p ^ w[2*i];
        return p;
    endfunction

    // Track the last word seen valid on the wires.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else if (bus_vld_o) last_q <= bus_o[DW-1:0];
    end

    // R5
    no_fp_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld_o |-> !bad_pattern(bus_o));

    // R4
    parity_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld_o |-> (bus_o[DW] == copy_parity(bus_o)));

    // R3
    toggle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld_o |-> ($countones(bus_o[DW-1:0] ^ last_q) <= NW));

    // R6
    enc_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_vld_i |=> bus_vld_o);

    // R6
    enc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_vld_i |=> (!bus_vld_o && $stable(bus_o)));

    // R7
    dec_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld_i |=> dec_vld_o);

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld_i |=> (!dec_vld_o && $stable(dec_data_o)));

endmodule

bind dapbi_codec dapbi_codec_chk #(.K(K)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_vld_i  (enc_vld_i),
    .bus_o      (bus_o),
    .bus_vld_o  (bus_vld_o),
    .bus_vld_i  (bus_vld_i),
    .dec_vld_o  (dec_vld_o),
    .dec_data_o (dec_data_o)
);

// File: tb/dapbi_codec_tb_top.sv
// Scoreboard bench: a driver pushes expected wire words and data, a
// monitor pops and compares them as the codec produces results.
module dapbi_codec_tb_top;
    localparam int K  = 8;
    localparam int NW = K + 1;
    localparam int DW = 2 * NW;
    localparam int BW = DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_vld_i = 1'b0;
    logic [K-1:0]  enc_data_i = '0;
    logic [BW-1:0] bus_o;
    logic          bus_vld_o;
    logic [BW-1:0] bus_i;
    logic          dec_vld_o;
    logic [K-1:0]  dec_data_o;
    logic [BW-1:0] drv_err = '0;
    logic [BW-1:0] err_q = '0;

    int checks = 0;
    int errors = 0;

    logic [BW-1:0] exp_bus_q[$];
    logic [K-1:0]  exp_dat_q[$];
    logic [DW-1:0] model_prev = '0;

    always #2 clk = ~clk;

    assign bus_i = bus_o ^ err_q;

    dapbi_codec #(.K(K)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_vld_i  (enc_vld_i),
        .enc_data_i (enc_data_i),
        .bus_o      (bus_o),
        .bus_vld_o  (bus_vld_o),
        .bus_i      (bus_i),
        .bus_vld_i  (bus_vld_o),
        .dec_vld_o  (dec_vld_o),
        .dec_data_o (dec_data_o)
    );

    // Error mask travels with the word it belongs to.
    always @(posedge clk) err_q <= enc_vld_i ? drv_err : '0;

    function automatic logic [BW-1:0] model_enc(input logic [DW-1:0] prev,
                                                input logic [K-1:0] d);
        logic [NW-1:0] w;
        logic [DW-1:0] c;
        w = {1'b0, d};
        for (int j = 0; j < NW; j++) begin c[2*j] = w[j]; c[2*j+1] = w[j]; end
        if ($countones(c ^ prev) > NW) w = {1'b1, ~d};
        for (int j = 0; j < NW; j++) begin c[2*j] = w[j]; c[2*j+1] = w[j]; end
        return {^w, c};
    endfunction

    function automatic logic has_fp(input logic [BW-1:0] w);
        for (int i = 0; i + 2 < BW; i++)
            if ((w[i] ^ w[i+1]) && (w[i+1] ^ w[i+2])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [K-1:0] d, input int errw);
        logic [BW-1:0] e;
        e = model_enc(model_prev, d);
        model_prev = e[DW-1:0];
        exp_bus_q.push_back(e);
        exp_dat_q.push_back(d);
        enc_vld_i  = 1'b1;
        enc_data_i = d;
        drv_err    = (errw >= 0) ? (BW'(1) << errw) : '0;
        @(negedge clk);
        enc_vld_i = 1'b0;
        drv_err   = '0;
        // R6: one cycle of encoder latency
        check(bus_vld_o === 1'b1, "R6 latency", 32'(bus_vld_o), 32'd1);
    endtask

    task automatic idle_check(input int n);
        logic [BW-1:0] b;
        logic [K-1:0]  d;
        enc_vld_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        b = bus_o;
        d = dec_data_o;
        repeat (n) @(negedge clk);
        check(bus_o === b && bus_vld_o === 1'b0, "R6 hold", 32'(bus_o), 32'(b));
        check(dec_data_o === d && dec_vld_o === 1'b0, "R9 hold",
              32'(dec_data_o), 32'(d));
    endtask

    // Monitor: compare wires and decoded data against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_vld_o) begin
                if (exp_bus_q.size() == 0) begin
                    check(1'b0, "R6 unexpected word", 32'(bus_o), 32'd0);
                end else begin
                    logic [BW-1:0] e;
                    e = exp_bus_q.pop_front();
                    check(bus_o === e, "R2 R3 R4 wires", 32'(bus_o), 32'(e));
                end
                check(!has_fp(bus_o), "R5 pattern", 32'(bus_o), 32'd0);
            end
            if (dec_vld_o) begin
                if (exp_dat_q.size() == 0) begin
                    check(1'b0, "R7 unexpected data", 32'(dec_data_o), 32'd0);
                end else begin
                    logic [K-1:0] d;
                    d = exp_dat_q.pop_front();
                    check(dec_data_o === d, "R7 R8 data", 32'(dec_data_o), 32'(d));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(bus_o === '0 && bus_vld_o === 1'b0, "R1 enc reset",
              32'(bus_o), 32'd0);
        check(dec_data_o === '0 && dec_vld_o === 1'b0, "R1 dec reset",
              32'(dec_data_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: threshold boundary from a zero history
        send(8'h00, -1);
        send(8'h0F, -1);   // 4 bits differ: 8 toggles, no invert
        send(8'h00, -1);
        send(8'h1F, -1);   // 5 bits differ: 10 toggles, invert
        send(8'hFF, -1);
        send(8'hAA, -1);
        send(8'h55, -1);
        idle_check(4);

        // R8: one flipped wire at every position, flag and parity included
        for (int w = 0; w < BW; w++) send(K'($urandom), w);
        for (int w = 0; w < BW; w++) send(8'hF0 ^ K'(w), w);
        idle_check(3);

        // R6: history must survive idle gaps
        for (int n = 0; n < 48; n++) begin
            send(K'($urandom), -1);
            if (n % 8 == 7) idle_check(2);
        end

        repeat (4) @(negedge clk);
        check(exp_bus_q.size() == 0 && exp_dat_q.size() == 0, "R7 drained",
              32'(exp_dat_q.size()), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule